// File: doc/BRIEF.md
# Key-to-Tone Handshake Bridge

This block connects a key-entry front end to a tone generator that runs at an unrelated pace. The front end offers a key code together with a strobe that lasts one clock cycle. The tone generator asks for work by raising a request line. It then expects a ready line back from this block, and it expects the code to stay steady until it lowers the request again.

A small control FSM makes sure that only the first key pressed after a request is taken. Every key pressed while a tone is still being served is dropped. The FSM also walks the four-phase request/ready exchange to its end. A capture register with an enable holds the chosen code and drives it to the tone generator.

A parameter selects between two ways of storing the state: one-hot or binary. Both give the same behaviour at the ports.

Top module: `key_tone_bridge`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `rdy_out` to 0 and `code_out` to all zeros, and returns the FSM to waiting for a request.
- R2: The first `key_stb` sampled high while the block is armed loads `key_code` into `code_out` at that same edge.
- R3: A `key_stb` sampled while the block is not armed leaves `code_out` unchanged. This covers idle, ready and release phases.
- R4: The block becomes armed only on the edge after the one where `req_in` is sampled high in the idle phase. A strobe sampled on that first edge is not captured.
- R5: `rdy_out` goes to 1 on the same edge that captures a code.
- R6: `code_out` does not change while `rdy_out` is 1.
- R7: While `rdy_out` is 1 and `req_in` is sampled high, `rdy_out` stays 1 on the next cycle.
- R8: When `req_in` is sampled low while `rdy_out` is 1, `rdy_out` is 0 after that edge.
- R9: After `rdy_out` falls, the block spends exactly one release cycle in which `req_in` is not examined. It then returns to idle, where a request that is still high arms it on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| key_code | input | CODE_W | Key code from the front end, valid when `key_stb` is high |
| key_stb | input | 1 | One-cycle strobe marking a new key code |
| req_in | input | 1 | Request from the tone generator for a new code |
| code_out | output | CODE_W | Captured code presented to the tone generator |
| rdy_out | output | 1 | Ready line telling the tone generator the code is valid |

## Verification
A state register stuck in or skipping a phase shows up at the ports within one cycle. A skipped release cycle lets `rdy_out` come back too early, a missing armed phase leaves `rdy_out` low after a strobe, and an extra armed phase overwrites `code_out` with a stray key. A wrong capture enable corrupts `code_out` on the very edge where a decoy strobe is offered during the idle, ready or release phase. The bench places such a decoy in each phase for every code value, so any such fault is exposed on the following cycle.

// File: rtl/bridge_pkg.sv
`timescale 1ns/1ps
package bridge_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_ARMED   = 2'd1,
      ST_READY   = 2'd2,
      ST_RELEASE = 2'd3
   } bridge_state_e;

   localparam int unsigned NUM_STATES = 4;

   // Next-state function shared by every storage variant.
   function automatic bridge_state_e step_state(input bridge_state_e cur,
                                                input logic req,
                                                input logic stb);
      bridge_state_e nxt;
      nxt = cur;
      unique case (cur)
         ST_IDLE:    if (req)  nxt = ST_ARMED;
         ST_ARMED:   if (stb)  nxt = ST_READY;
         ST_READY:   if (!req) nxt = ST_RELEASE;
         ST_RELEASE: nxt = ST_IDLE;
         default:    nxt = ST_IDLE;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/bridge_capture.sv
`timescale 1ns/1ps
module bridge_capture #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_en,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);

   logic [WIDTH-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (rst)
         hold_q <= '0;
      else if (load_en)
         hold_q <= d_in;
   end

   assign q_out = hold_q;

endmodule

// File: rtl/bridge_ctrl.sv
`timescale 1ns/1ps
module bridge_ctrl
   import bridge_pkg::*;
#(
   parameter bit ONE_HOT = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req_in,
   input  logic          key_stb,
   output logic          load_en,
   output logic          rdy_out,
   output bridge_state_e state_o
);

   localparam int unsigned ST_BITS = $bits(bridge_state_e);

   bridge_state_e cur_st;
   bridge_state_e nxt_st;
   logic          rdy_q;

   assign nxt_st = step_state(cur_st, req_in, key_stb);

   generate
      if (ONE_HOT) begin : g_onehot
         logic [NUM_STATES-1:0] oh_q;
         logic [NUM_STATES-1:0] oh_d;

         always_comb begin
            oh_d = '0;
            oh_d[nxt_st] = 1'b1;
         end

         always_ff @(posedge clk) begin
            if (rst) begin
               oh_q <= '0;
               oh_q[ST_IDLE] <= 1'b1;
            end else begin
               oh_q <= oh_d;
            end
         end

         always_comb begin
            if (oh_q[ST_ARMED])
               cur_st = ST_ARMED;
            else if (oh_q[ST_READY])
               cur_st = ST_READY;
            else if (oh_q[ST_RELEASE])
               cur_st = ST_RELEASE;
            else
               cur_st = ST_IDLE;
         end
      end else begin : g_binary
         logic [ST_BITS-1:0] bin_q;

         always_ff @(posedge clk) begin
            if (rst)
               bin_q <= ST_IDLE;
            else
               bin_q <= nxt_st;
         end

         assign cur_st = bridge_state_e'(bin_q);
      end
   endgenerate

   // Ready flag is its own flop, loaded from the next-state decision.
   always_ff @(posedge clk) begin
      if (rst)
         rdy_q <= 1'b0;
      else
         rdy_q <= (nxt_st == ST_READY);
   end

   assign load_en = (cur_st == ST_ARMED) && key_stb;
   assign rdy_out = rdy_q;
   assign state_o = cur_st;

endmodule

// File: rtl/key_tone_bridge.sv
`timescale 1ns/1ps
module key_tone_bridge #(
   parameter int unsigned CODE_W  = 4,
   parameter bit          ONE_HOT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CODE_W-1:0] key_code,
   input  logic              key_stb,
   input  logic              req_in,
   output logic [CODE_W-1:0] code_out,
   output logic              rdy_out
);

   generate
      if (CODE_W < 1 || CODE_W > 16) begin : g_bad_width
         $error("key_tone_bridge: CODE_W must lie in 1..16");
      end
   endgenerate

   logic                     cap_en;
   bridge_pkg::bridge_state_e fsm_st;

   bridge_ctrl #(
      .ONE_HOT (ONE_HOT)
   ) u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .req_in  (req_in),
      .key_stb (key_stb),
      .load_en (cap_en),
      .rdy_out (rdy_out),
      .state_o (fsm_st)
   );

   bridge_capture #(
      .WIDTH (CODE_W)
   ) u_cap (
      .clk     (clk),
      .rst     (rst),
      .load_en (cap_en),
      .d_in    (key_code),
      .q_out   (code_out)
   );

endmodule

// File: rtl/bridge_chk.sv
`timescale 1ns/1ps
module bridge_chk #(
   parameter int unsigned CODE_W = 4
) (
   input logic              clk,
   input logic              rst,
   input logic [CODE_W-1:0] key_code,
   input logic              key_stb,
   input logic              req_in,
   input logic [CODE_W-1:0] code_out,
   input logic              rdy_out
);

   // R2
   capture_value_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(rdy_out) |-> (code_out == $past(key_code)));

   // R5
   rise_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(rdy_out) |-> $past(key_stb));

   // R3
   quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!key_stb && !rst) |=> $stable(code_out));

   // R6
   ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
      rdy_out |=> $stable(code_out));

   // R7
   ready_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (rdy_out && req_in) |=> rdy_out);

   // R8
   ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (rdy_out && !req_in) |=> !rdy_out);

   // R9
   release_gap_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rdy_out) |=> !rdy_out);

endmodule

bind key_tone_bridge bridge_chk #(
   .CODE_W (CODE_W)
) u_bridge_chk (
   .clk      (clk),
   .rst      (rst),
   .key_code (key_code),
   .key_stb  (key_stb),
   .req_in   (req_in),
   .code_out (code_out),
   .rdy_out  (rdy_out)
);

// File: tb/key_tone_bridge_test.sv
`timescale 1ns/1ps
module key_tone_bridge_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] key = 4'd0;
   logic       stb = 1'b0;
   logic       req = 1'b0;
   logic [3:0] code_out;
   logic       rdy_out;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   key_tone_bridge #(
      .CODE_W  (4),
      .ONE_HOT (1'b1)
   ) uut (
      .clk      (clk),
      .rst      (rst),
      .key_code (key),
      .key_stb  (stb),
      .req_in   (req),
      .code_out (code_out),
      .rdy_out  (rdy_out)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string rq, input logic [3:0] exp_code, input logic exp_rdy);
      total++;
      if (code_out !== exp_code || rdy_out !== exp_rdy) begin
         bad++;
         $display("FAIL %s: code_out=%0d rdy_out=%0d expected code_out=%0d rdy_out=%0d",
                  rq, code_out, rdy_out, exp_code, exp_rdy);
      end
   endtask

   initial begin
      logic [3:0] exp_code;
      logic [3:0] decoy;
      bit         armed;

      // R1: reset state
      repeat (3) tick();
      chk("R1", 4'd0, 1'b0);
      rst = 1'b0;
      exp_code = 4'd0;
      armed = 1'b0;

      for (int c = 0; c < 16; c++) begin
         decoy = 4'(c + 5);
         if (!armed) begin
            // R4: strobe on the edge where the request is first seen
            req = 1'b1; stb = 1'b1; key = decoy;
            tick();
            chk("R4", exp_code, 1'b0);
         end
         stb = 1'b0; key = decoy;
         for (int w = 0; w < c % 3; w++) begin
            tick();
            chk("R4", exp_code, 1'b0);
         end
         // R2 and R5: capture and ready on the same edge
         stb = 1'b1; key = 4'(c);
         tick();
         exp_code = 4'(c);
         chk("R2 R5", exp_code, 1'b1);
         // R6: decoy strobe while ready
         stb = 1'b1; key = decoy;
         tick();
         chk("R6", exp_code, 1'b1);
         // R7: ready held while request stays high
         stb = 1'b0;
         tick();
         chk("R7", exp_code, 1'b1);
         // R8: request dropped
         req = 1'b0; stb = 1'b1; key = decoy;
         tick();
         chk("R8", exp_code, 1'b0);
         if (c % 2 == 1) begin
            // R9: request during release ignored, armed one edge later
            req = 1'b1;
            tick();
            chk("R9", exp_code, 1'b0);
            tick();
            chk("R9", exp_code, 1'b0);
            armed = 1'b1;
         end else begin
            // R3: strobes in release and idle ignored
            tick();
            chk("R3", exp_code, 1'b0);
            tick();
            chk("R3", exp_code, 1'b0);
            armed = 1'b0;
         end
         stb = 1'b0;
      end

      // The last pass left the block armed; capture, then reset mid-transfer.
      stb = 1'b1; key = 4'd9;
      tick();
      chk("R2", 4'd9, 1'b1);
      rst = 1'b1; stb = 1'b0;
      tick();
      chk("R1", 4'd0, 1'b0);
      tick();
      rst = 1'b0; req = 1'b0; stb = 1'b1; key = 4'd6;
      tick();
      chk("R3", 4'd0, 1'b0);
      req = 1'b1; stb = 1'b0;
      tick();
      chk("R4", 4'd0, 1'b0);
      stb = 1'b1; key = 4'd6;
      tick();
      chk("R2", 4'd6, 1'b1);
      stb = 1'b0; req = 1'b0;
      tick();
      chk("R8", 4'd6, 1'b0);

      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(5 * 100000);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule